// File: doc/BRIEF.md
# Ethernet Controller Command and Status Register File

This block holds the four 16-bit control and status registers of a descriptor-based Ethernet controller. Software reaches them indirectly. It first writes a register number to a pointer port, then reads or writes the selected register through a data port. Register 0 carries four kinds of bit:

- command bits that software sets;
- status flags that software clears;
- the receiver and transmitter enable state;
- the interrupt enable and the interrupt summary.

Registers 1 and 2 hold the address of the initialization block. Register 3 holds bus control bits.

A write to register 0 can raise stop, start or init, and each of these edges drives a different state change. The block reports the outcomes to the descriptor engines through one-cycle pulses: initialization, start and transmit poll. It also drives an interrupt request. The engines report events back through a six-bit event vector, and each event sets a status flag.

A two-state machine records whether initialization has ever run. `CTL_COLD` is the state after reset. The transition `INIT_RUN` moves it to `CTL_PRIMED` on the first write that runs initialization. `CTL_PRIMED` is left only by reset. A transmit poll is issued only in `CTL_PRIMED`.

Top module: `eth_csr_regs`

## Requirements
- R1: After reset, register 0 reads 0x0004 (stop bit only), registers 1 to 3 read 0, the pointer reads 0, and irq is low.
- R2: Bus address 0 is the data port and bus address 1 is the pointer port. A pointer write keeps only wdata[1:0], and a pointer read returns it zero-extended. A read of any other bus address returns 0xFFFF, and a write to such an address has no effect.
- R3: Register 0 bit positions are: 15 error, 14 babble, 13 collision error, 12 missed frame, 11 memory error, 10 receive interrupt, 9 transmit interrupt, 8 init done, 7 interrupt flag, 6 interrupt enable, 5 receiver on, 4 transmitter on, 3 transmit demand, 2 stop, 1 start, 0 init. In a write to register 0, a 1 in bit 0, 1, 2 or 3 sets that bit, and a 0 leaves it unchanged. A 1 in bits 14 to 8 clears that flag. Bit 6 takes the written value.
- R4: A write that raises stop sets register 0 to 0x0004 and clears register 3.
- R5: A write that raises start, when the old value had stop or init set, clears stop and pulses start_pulse. It sets transmitter on unless mode_no_tx is high, and sets receiver on unless mode_no_rx is high.
- R6: A write that raises init, when the old value had stop set, pulses init_pulse, sets init done, and clears stop, receiver on and transmitter on. If start rises in the same write and the start rule of R5 applies, init_pulse and init done happen as well.
- R7: Transmit demand always reads back as 0. A write with bit 3 set pulses tx_poll when start is set after the write and initialization has run since reset.
- R8: Writes to registers 1, 2 and 3 take effect only while stop is set. Register 1 forces bit 0 to 0, register 2 keeps bits 7:0, and register 3 keeps bits 2:0.
- R9: byte_swap equals register 3 bit 2. init_addr equals {register 2 bits 7:0, register 1}.
- R10: The interrupt flag (bit 7) reads 1 whenever babble, missed, memory error, receive interrupt, transmit interrupt or init done is set. Collision error does not set it. irq is high exactly when the interrupt flag and the interrupt enable are both set.
- R11: A read of register 0 returns the error bit (bit 15) as the OR of babble, collision error, missed and memory error.
- R12: Each bit of ev_status sets one status flag: bit 0 babble, bit 1 collision error, bit 2 missed, bit 3 memory error, bit 4 receive interrupt, bit 5 transmit interrupt. Events are ignored while stop is set after that cycle's write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | PORT_AW | Port select: 0 data, 1 pointer, others unmapped |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| mode_no_tx | input | 1 | Mode bit: start leaves transmitter off |
| mode_no_rx | input | 1 | Mode bit: start leaves receiver off |
| ev_status | input | 6 | Status event pulses from the engines |
| irq | output | 1 | Interrupt request |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| byte_swap | output | 1 | Byte-swap selection from register 3 |
| init_addr | output | 24 | Initialization block address |
| init_pulse | output | 1 | One cycle: initialization runs |
| start_pulse | output | 1 | One cycle: controller started |
| tx_poll | output | 1 | One cycle: transmit ring poll requested |

## Verification
The assertions assume that the event inputs and mode bits are synchronous to clk. They also assume that only one bus operation, a read or a write, is presented per cycle. The bench changes every input just after the falling edge and clears the write strobe once each cycle ends. Events are driven both in cycles without a write and in cycles with one, so the rule that a write settles before events are merged is exercised. Random register-0 words usually have the stop bit cleared, so that the start, init and poll paths are reached often.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;

    localparam int CSR_W    = 16;
    localparam int PTR_W    = 2;
    localparam int EV_W     = 6;
    localparam int NUM_CFG  = 3;
    localparam int ADDR_HI  = 8;

    localparam int B_ERR  = 15;
    localparam int B_BABL = 14;
    localparam int B_CERR = 13;
    localparam int B_MISS = 12;
    localparam int B_MERR = 11;
    localparam int B_RINT = 10;
    localparam int B_TINT = 9;
    localparam int B_IDON = 8;
    localparam int B_INTR = 7;
    localparam int B_INEA = 6;
    localparam int B_RXON = 5;
    localparam int B_TXON = 4;
    localparam int B_TDMD = 3;
    localparam int B_STOP = 2;
    localparam int B_STRT = 1;
    localparam int B_INIT = 0;

    typedef logic [CSR_W-1:0] csr_t;

    localparam csr_t STOP_ONLY = csr_t'(1) << B_STOP;
    localparam csr_t CMD_MASK  = 16'h000F;
    localparam csr_t W1C_MASK  = 16'h7F00;
    localparam csr_t INTR_SRC  = 16'h5F00;
    localparam csr_t ERR_SRC   = 16'h7800;
    localparam csr_t STORED    = ~((csr_t'(1) << B_ERR) | (csr_t'(1) << B_INTR));

    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_PTR  = 2'd1
    } port_t;

    typedef enum logic {
        CTL_COLD   = 1'b0,
        CTL_PRIMED = 1'b1
    } ctl_state_t;

    function automatic csr_t ev_to_csr(input logic [EV_W-1:0] ev);
        csr_t r;
        r = '0;
        for (int i = 0; i < EV_W; i++) begin
            r[B_BABL - i] = ev[i];
        end
        return r;
    endfunction

    function automatic csr_t cfg_mask(input int idx);
        csr_t m;
        unique case (idx)
            1:       m = 16'hFFFE;
            2:       m = 16'h00FF;
            default: m = 16'h0007;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/eth_csr_cmd.sv
module eth_csr_cmd
    import eth_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr0,
    input  csr_t            wdata,
    input  logic            mode_no_tx,
    input  logic            mode_no_rx,
    input  logic [EV_W-1:0] ev_status,
    output csr_t            csr0_q,
    output logic            clr_cfg3,
    output logic            init_pulse,
    output logic            start_pulse,
    output logic            tx_poll
);

    ctl_state_t state_q, state_d;
    csr_t       csr0_d;
    logic       stop_edge, start_take, init_take, poll_take;

    // Next value of register 0 and the transition of the state machine.
    always_comb begin
        csr_t n;
        n          = csr0_q;
        stop_edge  = 1'b0;
        start_take = 1'b0;
        init_take  = 1'b0;
        poll_take  = 1'b0;
        state_d    = state_q;

        if (wr0) begin
            n[B_INEA] = wdata[B_INEA];
            n = n | (wdata & CMD_MASK);
            n = n & ~(wdata & W1C_MASK);

            if (n[B_STOP] && !csr0_q[B_STOP]) begin
                n         = STOP_ONLY;
                stop_edge = 1'b1;
            end else if (n[B_STRT] && !csr0_q[B_STRT] &&
                         (csr0_q[B_STOP] || csr0_q[B_INIT])) begin
                start_take = 1'b1;
                n[B_STOP]  = 1'b0;
                if (!mode_no_tx) n[B_TXON] = 1'b1;
                if (!mode_no_rx) n[B_RXON] = 1'b1;
                if (n[B_INIT] && !csr0_q[B_INIT]) begin
                    init_take = 1'b1;
                    n[B_IDON] = 1'b1;
                end
            end else if (n[B_INIT] && !csr0_q[B_INIT] && csr0_q[B_STOP]) begin
                init_take = 1'b1;
                n[B_IDON] = 1'b1;
                n[B_RXON] = 1'b0;
                n[B_TXON] = 1'b0;
                n[B_STOP] = 1'b0;
            end
        end

        unique case (state_q)
            CTL_COLD:   if (init_take) state_d = CTL_PRIMED;   // INIT_RUN
            CTL_PRIMED: state_d = CTL_PRIMED;
            default:    state_d = CTL_COLD;
        endcase

        if (n[B_TDMD] && n[B_STRT] && (state_d == CTL_PRIMED)) begin
            poll_take = 1'b1;
        end
        n[B_TDMD] = 1'b0;

        if (!n[B_STOP]) begin
            n = n | ev_to_csr(ev_status);
        end

        csr0_d = n & STORED;
    end

    assign clr_cfg3 = stop_edge;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTL_COLD;
            csr0_q  <= STOP_ONLY;
        end else begin
            state_q <= state_d;
            csr0_q  <= csr0_d;
        end
    end

    // Registered pulse outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_pulse  <= 1'b0;
            start_pulse <= 1'b0;
            tx_poll     <= 1'b0;
        end else begin
            init_pulse  <= init_take;
            start_pulse <= start_take;
            tx_poll     <= poll_take;
        end
    end

endmodule

// File: rtl/eth_csr_cfg.sv
module eth_csr_cfg
    import eth_csr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_data,
    input  logic [PTR_W-1:0]            ptr,
    input  csr_t                        wdata,
    input  logic                        unlocked,
    input  logic                        clr_cfg3,
    output logic [NUM_CFG-1:0][CSR_W-1:0] cfg_q
);

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam int   IDX  = g + 1;
        localparam csr_t MASK = cfg_mask(IDX);
        logic hit;
        assign hit = wr_data && unlocked && (ptr == PTR_W'(IDX));

        if (IDX == NUM_CFG) begin : g_clr
            always_ff @(posedge clk) begin
                if (!rst_n)        cfg_q[g] <= '0;
                else if (clr_cfg3) cfg_q[g] <= '0;
                else if (hit)      cfg_q[g] <= wdata & MASK;
            end
        end else begin : g_keep
            always_ff @(posedge clk) begin
                if (!rst_n)   cfg_q[g] <= '0;
                else if (hit) cfg_q[g] <= wdata & MASK;
            end
        end
    end

endmodule

// File: rtl/eth_csr_rdmux.sv
module eth_csr_rdmux
    import eth_csr_pkg::*;
#(
    parameter int PORT_AW = 2
) (
    input  logic [PORT_AW-1:0]          bus_addr,
    input  logic [PTR_W-1:0]            ptr,
    input  csr_t                        csr0_q,
    input  logic [NUM_CFG-1:0][CSR_W-1:0] cfg_q,
    output csr_t                        rdata,
    output logic                        intr_flag
);

    csr_t csr0_view;

    always_comb begin
        intr_flag           = |(csr0_q & INTR_SRC);
        csr0_view           = csr0_q;
        csr0_view[B_INTR]   = intr_flag;
        csr0_view[B_ERR]    = |(csr0_q & ERR_SRC);

        if (bus_addr == PORT_AW'(PORT_DATA)) begin
            if (ptr == '0) rdata = csr0_view;
            else           rdata = cfg_q[ptr - PTR_W'(1)];
        end else if (bus_addr == PORT_AW'(PORT_PTR)) begin
            rdata = csr_t'(ptr);
        end else begin
            rdata = '1;
        end
    end

endmodule

// File: rtl/eth_csr_regs.sv
module eth_csr_regs
    import eth_csr_pkg::*;
#(
    parameter int PORT_AW = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_AW-1:0] bus_addr,
    input  logic               bus_wr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic               mode_no_tx,
    input  logic               mode_no_rx,
    input  logic [5:0]         ev_status,
    output logic               irq,
    output logic               rx_on,
    output logic               tx_on,
    output logic               byte_swap,
    output logic [23:0]        init_addr,
    output logic               init_pulse,
    output logic               start_pulse,
    output logic               tx_poll
);

    logic [PTR_W-1:0]               csr_ptr;
    csr_t                           csr0_q, csr1_q, csr2_q, csr3_q;
    logic [NUM_CFG-1:0][CSR_W-1:0]  cfg_q;
    logic                           wr_data, wr_ptr, clr_cfg3, intr_flag;

    assign wr_data = bus_wr && (bus_addr == PORT_AW'(PORT_DATA));
    assign wr_ptr  = bus_wr && (bus_addr == PORT_AW'(PORT_PTR));

    always_ff @(posedge clk) begin
        if (!rst_n)      csr_ptr <= '0;
        else if (wr_ptr) csr_ptr <= bus_wdata[PTR_W-1:0];
    end

    eth_csr_cmd u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr0         (wr_data && (csr_ptr == '0)),
        .wdata       (bus_wdata),
        .mode_no_tx  (mode_no_tx),
        .mode_no_rx  (mode_no_rx),
        .ev_status   (ev_status),
        .csr0_q      (csr0_q),
        .clr_cfg3    (clr_cfg3),
        .init_pulse  (init_pulse),
        .start_pulse (start_pulse),
        .tx_poll     (tx_poll)
    );

    eth_csr_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .ptr      (csr_ptr),
        .wdata    (bus_wdata),
        .unlocked (csr0_q[B_STOP]),
        .clr_cfg3 (clr_cfg3),
        .cfg_q    (cfg_q)
    );

    eth_csr_rdmux #(.PORT_AW(PORT_AW)) u_rd (
        .bus_addr  (bus_addr),
        .ptr       (csr_ptr),
        .csr0_q    (csr0_q),
        .cfg_q     (cfg_q),
        .rdata     (bus_rdata),
        .intr_flag (intr_flag)
    );

    assign csr1_q    = cfg_q[0];
    assign csr2_q    = cfg_q[1];
    assign csr3_q    = cfg_q[2];
    assign irq       = intr_flag && csr0_q[B_INEA];
    assign rx_on     = csr0_q[B_RXON];
    assign tx_on     = csr0_q[B_TXON];
    assign byte_swap = csr3_q[2];
    assign init_addr = {csr2_q[ADDR_HI-1:0], csr1_q};

endmodule

// File: rtl/eth_csr_regs_chk.sv
module eth_csr_regs_chk #(
    parameter int PORT_AW = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PORT_AW-1:0] bus_addr,
    input logic               bus_wr,
    input logic [15:0]        bus_wdata,
    input logic [15:0]        bus_rdata,
    input logic               irq,
    input logic               init_pulse,
    input logic [1:0]         csr_ptr,
    input logic [15:0]        csr0_q,
    input logic [15:0]        csr1_q,
    input logic [15:0]        csr2_q,
    input logic [15:0]        csr3_q
);

    logic wr_reg0, wr_cfg;
    assign wr_reg0 = bus_wr && (bus_addr == '0) && (csr_ptr == 2'd0);
    assign wr_cfg  = bus_wr && (bus_addr == '0) && (csr_ptr != 2'd0);

    always_comb begin
        if (rst_n && (bus_addr > PORT_AW'(1))) begin
            AST_UNMAPPED_ONES: assert (bus_rdata == 16'hFFFF); // R2
        end
    end

    AST_STOP_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (wr_reg0 && bus_wdata[2] && !csr0_q[2]) |=> (csr0_q == 16'h0004 && csr3_q == 16'h0000)); // R4
    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n) (wr_cfg && !csr0_q[2]) |=> ($stable(csr1_q) && $stable(csr2_q) && $stable(csr3_q))); // R8
    AST_TDMD_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !csr0_q[3]); // R7
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) irq |-> csr0_q[6]); // R10
    AST_INIT_DONE: assert property (@(posedge clk) disable iff (!rst_n) init_pulse |-> csr0_q[8]); // R6

endmodule

bind eth_csr_regs eth_csr_regs_chk #(.PORT_AW(PORT_AW)) u_chk (.*);

// File: tb/eth_csr_regs_tb.sv
module eth_csr_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mode_no_tx = 1'b0, mode_no_rx = 1'b0;
    logic [5:0]  ev_status = '0;
    logic        irq, rx_on, tx_on, byte_swap, init_pulse, start_pulse, tx_poll;
    logic [23:0] init_addr;

    int n_checks = 0;
    int n_errors = 0;

    // Bench reference state.
    logic [15:0] m0, m1, m2, m3;
    logic [1:0]  mptr;
    logic        mprimed, e_init, e_start, e_poll;

    always #5 clk = ~clk;

    eth_csr_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_no_tx(mode_no_tx),
        .mode_no_rx(mode_no_rx), .ev_status(ev_status), .irq(irq), .rx_on(rx_on),
        .tx_on(tx_on), .byte_swap(byte_swap), .init_addr(init_addr),
        .init_pulse(init_pulse), .start_pulse(start_pulse), .tx_poll(tx_poll)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] view0();
        logic [15:0] v;
        v = m0;
        v[7]  = |(m0 & 16'h5F00);
        v[15] = |(m0 & 16'h7800);
        return v;
    endfunction

    function automatic logic [15:0] exp_read(input logic [1:0] a);
        if (a == 2'd1) return {14'd0, mptr};
        if (a != 2'd0) return 16'hFFFF;
        case (mptr)
            2'd0: return view0();
            2'd1: return m1;
            2'd2: return m2;
            default: return m3;
        endcase
    endfunction

    task automatic model_step(input logic w, input logic [1:0] a, input logic [15:0] d, input logic [5:0] ev);
        logic [15:0] n;
        logic it;
        n = m0; e_init = 0; e_start = 0; e_poll = 0; it = 0;
        if (w && a == 2'd1) mptr = d[1:0];
        if (w && a == 2'd0 && mptr != 2'd0 && m0[2]) begin
            if (mptr == 2'd1) m1 = d & 16'hFFFE;
            if (mptr == 2'd2) m2 = d & 16'h00FF;
            if (mptr == 2'd3) m3 = d & 16'h0007;
        end
        if (w && a == 2'd0 && mptr == 2'd0) begin
            n[6] = d[6];
            n = n | (d & 16'h000F);
            n = n & ~(d & 16'h7F00);
            if (n[2] && !m0[2]) begin
                n = 16'h0004; m3 = 0;
            end else if (n[1] && !m0[1] && (m0[2] || m0[0])) begin
                e_start = 1; n[2] = 0;
                if (!mode_no_tx) n[4] = 1;
                if (!mode_no_rx) n[5] = 1;
                if (n[0] && !m0[0]) begin it = 1; n[8] = 1; end
            end else if (n[0] && !m0[0] && m0[2]) begin
                it = 1; n[8] = 1; n[5] = 0; n[4] = 0; n[2] = 0;
            end
            e_init = it;
            if (it) mprimed = 1;
            e_poll = n[3] && n[1] && mprimed;
            n[3] = 0;
        end
        if (!n[2]) n = n | {1'b0, ev[0], ev[1], ev[2], ev[3], ev[4], ev[5], 9'd0};
        m0 = n & 16'h7F7F;
    endtask

    // One clock: drive after the falling edge, check outputs at the next falling edge.
    task automatic cyc(input logic w, input logic [1:0] a, input logic [15:0] d, input logic [5:0] ev);
        bus_wr = w; bus_addr = a; bus_wdata = d; ev_status = ev;
        @(posedge clk);
        model_step(w, a, d, ev);
        @(negedge clk);
        bus_wr = 0; ev_status = 0;
        chk("R6 init_pulse", init_pulse, e_init);
        chk("R5 start_pulse", start_pulse, e_start);
        chk("R7 tx_poll", tx_poll, e_poll);
        chk("R10 irq", irq, view0() >> 7 & m0[6]);
        chk("R5 rx_on", rx_on, m0[5]);
        chk("R5 tx_on", tx_on, m0[4]);
        chk("R9 byte_swap", byte_swap, m3[2]);
        chk("R9 init_addr", init_addr, {m2[7:0], m1});
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [15:0] exp);
        bus_wr = 0; bus_addr = a; #1;
        chk(req, bus_rdata, exp);
        chk({req, " model"}, bus_rdata, exp_read(a));
    endtask

    task automatic rd_reg(input string req, input logic [1:0] r, input logic [15:0] exp);
        cyc(1, 2'd1, {14'd0, r}, 0);
        rd(req, 2'd0, exp);
    endtask

    initial begin
        #(200000 * 10);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m0 = 16'h0004; m1 = 0; m2 = 0; m3 = 0; mptr = 0; mprimed = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd("R1 csr0", 2'd0, 16'h0004);
        rd("R1 ptr", 2'd1, 16'h0000);
        chk("R1 irq", irq, 0);
        rd_reg("R1 csr3", 2'd3, 16'h0000);

        // R2 pointer masking and unmapped ports
        cyc(1, 2'd1, 16'hFFFD, 0);
        rd("R2 ptr low bits", 2'd1, 16'h0001);
        rd("R2 unmapped 2", 2'd2, 16'hFFFF);
        rd("R2 unmapped 3", 2'd3, 16'hFFFF);
        cyc(1, 2'd2, 16'h0003, 0);
        rd("R2 unmapped write ignored", 2'd1, 16'h0001);

        // R8/R9 configuration while stopped
        cyc(1, 2'd0, 16'h1235, 0);
        rd("R8 csr1 mask", 2'd0, 16'h1234);
        rd_reg("R8 csr2 before", 2'd2, 16'h0000);
        cyc(1, 2'd0, 16'hABCD, 0);
        rd("R8 csr2 mask", 2'd0, 16'h00CD);
        rd_reg("R8 csr3 before", 2'd3, 16'h0000);
        cyc(1, 2'd0, 16'hFFFF, 0);
        rd("R8 csr3 mask", 2'd0, 16'h0007);
        chk("R9 byte_swap on", byte_swap, 1);
        chk("R9 init_addr value", init_addr, 24'hCD1234);

        // R6 init from stopped
        cyc(1, 2'd1, 16'h0000, 0);
        cyc(1, 2'd0, 16'h0001, 0);
        chk("R6 init pulse seen", init_pulse, 1);
        rd("R6 init done", 2'd0, 16'h0181);
        chk("R10 irq without enable", irq, 0);

        // R8 locked when not stopped
        cyc(1, 2'd1, 16'h0001, 0);
        cyc(1, 2'd0, 16'h5678, 0);
        rd("R8 csr1 locked", 2'd0, 16'h1234);
        cyc(1, 2'd1, 16'h0000, 0);

        // R3/R10 enable and write-one-to-clear
        cyc(1, 2'd0, 16'h0040, 0);
        rd("R3 inea set", 2'd0, 16'h01C1);
        chk("R10 irq raised", irq, 1);
        cyc(1, 2'd0, 16'h0140, 0);
        rd("R3 idon cleared", 2'd0, 16'h0041);
        chk("R10 irq dropped", irq, 0);

        // R5 start, R7 transmit demand
        cyc(1, 2'd0, 16'h0042, 0);
        chk("R5 start pulse seen", start_pulse, 1);
        rd("R5 running", 2'd0, 16'h0073);
        cyc(1, 2'd0, 16'h004A, 0);
        chk("R7 poll seen", tx_poll, 1);
        rd("R7 tdmd reads zero", 2'd0, 16'h0073);

        // R12/R11 events
        cyc(0, 2'd0, 16'h0000, 6'h3F);
        rd("R11 all events", 2'd0, 16'hFEF3);
        chk("R10 irq from events", irq, 1);
        cyc(1, 2'd0, 16'h7E40, 0);
        rd("R3 flags cleared", 2'd0, 16'h0073);
        cyc(0, 2'd0, 16'h0000, 6'h02);
        rd("R11 collision only", 2'd0, 16'hA073);
        chk("R10 collision no irq", irq, 0);
        cyc(1, 2'd0, 16'h2040, 0);

        // R4 stop
        cyc(1, 2'd0, 16'h0004, 0);
        rd("R4 stop value", 2'd0, 16'h0004);
        chk("R4 csr3 cleared", byte_swap, 0);
        rd_reg("R4 csr3 zero", 2'd3, 16'h0000);
        cyc(1, 2'd1, 16'h0000, 0);

        // R12 events ignored while stopped
        cyc(0, 2'd0, 16'h0000, 6'h3F);
        rd("R12 ignored when stopped", 2'd0, 16'h0004);

        // R5 start with transmit disabled
        mode_no_tx = 1;
        cyc(1, 2'd0, 16'h0002, 0);
        rd("R5 no tx", 2'd0, 16'h0022);
        mode_no_tx = 0;

        // R6 init and start together
        cyc(1, 2'd0, 16'h0004, 0);
        cyc(1, 2'd0, 16'h0003, 0);
        chk("R6 both pulses", {init_pulse, start_pulse}, 2'b11);
        rd("R6 init with start", 2'd0, 16'h01B3);

        // Random phase
        for (int k = 0; k < 600; k++) begin
            int sel;
            logic [15:0] w;
            sel = $urandom % 10;
            mode_no_tx = ($urandom % 4) == 0;
            mode_no_rx = ($urandom % 4) == 0;
            w = 16'($urandom);
            if (sel < 3) begin
                cyc(1, 2'd1, w, 6'($urandom));
            end else if (sel < 7) begin
                if ($urandom % 4 != 0) w[2] = 0;
                cyc(1, 2'd0, w, (($urandom % 2) == 0) ? 6'($urandom) : 6'd0);
            end else if (sel < 8) begin
                cyc(0, 2'd0, 16'h0000, 6'($urandom));
            end else if (sel < 9) begin
                cyc(1, 2'(2 + $urandom % 2), w, 0);
            end else begin
                rd("R3 random read data", 2'd0, exp_read(2'd0));
                rd("R2 random read ptr", 2'd1, exp_read(2'd1));
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule